// File: doc/BRIEF.md
# Coprocessor Load/Store Beat Sequencer

This block sits between a 32-bit memory data path and a file of 64-bit coprocessor registers. For each coprocessor load or store it counts the data beats, decides which half of the addressed register each 32-bit word belongs to, and tells the host pipeline after every beat whether one more beat is wanted or the transfer has finished. A bit in the instruction word selects a wide transfer of two words; otherwise one word moves. The half used by a one-word transfer depends on whether the operand is floating point or integer. An integer word that is loaded is sign-extended to fill the whole register.

A transfer opens with a one-cycle start strobe. The start strobe stands for the non-data phase. It takes in the instruction word and the operand selects, clears the beat count and reports completion at once. Each later data beat is marked by a beat strobe. The endianness input is sampled on every beat. The block also carries direct host moves: a 32-bit word can be written into, or read from, either half of a register without the beat machinery. The register file sits outside the block and is reached through one write port and one read port.

Top module: `cop_xfer_seq`

## Requirements
- R1: After reset, with no strobe asserted, `beat_more`, `beat_done` and `rf_we` are all zero.
- R2: In any cycle with `phase_start` high, `beat_done` is high and `beat_more` is low in that same cycle. In that cycle the block clears the beat count, captures the register index from `instr[15:12]`, the wide flag from `instr[22]`, `is_store` and `is_int`, and ignores `beat_vld`. An unfinished wide transfer is abandoned.
- R3: In a wide transfer the first beat gives `beat_more`=1 and `beat_done`=0. The second beat gives `beat_done`=1 and `beat_more`=0. A further beat after that starts a new count at beat 0.
- R4: In a wide load, beat 0 writes the upper half when `big_endian`=1 and the lower half when it is 0, and beat 1 writes the other half. `rf_we[1]` enables the upper half and `rf_we[0]` the lower half, and the loaded word appears in both halves of `rf_wr_data`. `rf_wr_idx` is the captured index.
- R5: A one-word float load (`is_int`=0) writes only the upper half (`rf_we`=2'b10) and reports done on its single beat.
- R6: A one-word integer load writes both halves (`rf_we`=2'b11), and `rf_wr_data` is the word sign-extended to 64 bits.
- R7: In a wide store, `st_data` follows the same half order as R4 (beat 0 is upper when big-endian), read from the captured register through `rf_rd_idx`/`rf_rd_data`. No store beat asserts `rf_we`.
- R8: A one-word float store drives the upper half on `st_data`, and a one-word integer store drives the lower half.
- R9: With `mv_wr` high, `host_wdata` is written into the register at `instr[19:16]`. The half is the upper one when `mv_upper`=1 (`rf_we`=2'b10) and the lower one otherwise (2'b01).
- R10: With `mv_rd` high, `rf_rd_idx` is `instr[19:16]` and `host_rdata` is the upper half when `mv_upper`=1 and the lower half otherwise. Otherwise `host_rdata` is zero.
- R11: A host move in a cycle where `phase_start` or `beat_vld` is high has no effect: `host_rdata` stays zero and the write port carries only the transfer's own write.
- R12: `beat_more` and `beat_done` are never high together, and each is high only in a cycle with `phase_start` or `beat_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_start | input | 1 | Non-data phase strobe; starts a transfer |
| beat_vld | input | 1 | One data beat in this cycle |
| is_store | input | 1 | 1 = store, 0 = load (captured at start) |
| is_int | input | 1 | 1 = integer operand, 0 = float (captured at start) |
| big_endian | input | 1 | Beat-to-half order, sampled per beat |
| instr | input | 32 | Instruction word |
| ld_data | input | 32 | Memory word for a load beat |
| st_data | output | 32 | Word for memory on a store beat |
| beat_more | output | 1 | Another beat is needed |
| beat_done | output | 1 | Transfer complete |
| mv_wr | input | 1 | Host-to-coprocessor move |
| mv_rd | input | 1 | Coprocessor-to-host move |
| mv_upper | input | 1 | Move addresses the upper half |
| host_wdata | input | 32 | Host move write word |
| host_rdata | output | 32 | Host move read word |
| rf_we | output | 2 | Half write enables: [1] upper, [0] lower |
| rf_wr_idx | output | 4 | Write register index |
| rf_wr_data | output | 64 | Write data |
| rf_rd_idx | output | 4 | Read register index |
| rf_rd_data | input | 64 | Read data from the register file |

## Verification
The hardest case to reach is a start strobe that lands in the middle of a wide transfer while a beat strobe is high in the same cycle. Here the beat must be dropped, the count cleared and the new mode captured. The bench opens a wide load, gives one beat so that more is pending, then raises both strobes together with a different instruction. It checks that nothing is written in that cycle and that the next beat behaves as the first beat of the new one-word transfer. Host moves are also collided with beats to show the beat path wins.

// File: rtl/cop_xfer_pkg.sv
package cop_xfer_pkg;

    // Half-enable encoding: bit 1 = upper half, bit 0 = lower half
    typedef enum logic [1:0] {
        HALF_NONE = 2'b00,
        HALF_LO   = 2'b01,
        HALF_HI   = 2'b10,
        HALF_BOTH = 2'b11
    } half_e;

    // Transfer mode captured by the start strobe
    typedef struct packed {
        logic wide;
        logic store;
        logic intg;
    } xfer_mode_t;

endpackage

// File: rtl/cop_xfer_ctrl.sv
module cop_xfer_ctrl
    import cop_xfer_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter int IDX_W    = 4,
    parameter int WIDE_BIT = 22,
    parameter int DST_LSB  = 12,
    parameter int BEATS    = 2,
    localparam int CNT_W   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phase_start,
    input  logic               beat_vld,
    input  logic               is_store,
    input  logic               is_int,
    input  logic [INSTR_W-1:0] instr,
    output logic               beat_acc,
    output logic [CNT_W-1:0]   beat_cnt,
    output logic [IDX_W-1:0]   reg_idx,
    output xfer_mode_t         mode,
    output logic               more,
    output logic               done
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        xfer_mode_t       mode;
    } ctrl_st_t;

    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        beat_acc = 1'b0;
        more     = 1'b0;
        done     = 1'b0;
        if (phase_start) begin
            // non-data phase: restart count, capture mode, complete now
            st_d.cnt        = '0;
            st_d.idx        = instr[DST_LSB +: IDX_W];
            st_d.mode.wide  = instr[WIDE_BIT];
            st_d.mode.store = is_store;
            st_d.mode.intg  = is_int;
            done            = 1'b1;
        end else if (beat_vld) begin
            beat_acc = 1'b1;
            if (!st_q.mode.wide || st_q.cnt == LAST_BEAT) begin
                done     = 1'b1;
                st_d.cnt = '0;
            end else begin
                more     = 1'b1;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_cnt = st_q.cnt;
    assign reg_idx  = st_q.idx;
    assign mode     = st_q.mode;

endmodule

// File: rtl/cop_xfer_steer.sv
module cop_xfer_steer
    import cop_xfer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 1,
    localparam int REG_W = 2 * DATA_W
) (
    input  logic              beat_acc,
    input  logic [CNT_W-1:0]  beat_cnt,
    input  xfer_mode_t        mode,
    input  logic              big_endian,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [REG_W-1:0]  rd_data,
    output half_e             we,
    output logic [REG_W-1:0]  wr_data,
    output logic [DATA_W-1:0] st_data
);

    logic pick_hi;

    always_comb begin
        // which half this beat touches
        if (mode.wide) begin
            pick_hi = (beat_cnt == '0) ? big_endian : !big_endian;
        end else begin
            pick_hi = !mode.intg;
        end

        we      = HALF_NONE;
        wr_data = {ld_data, ld_data};
        st_data = '0;
        if (beat_acc) begin
            if (mode.store) begin
                st_data = pick_hi ? rd_data[REG_W-1:DATA_W] : rd_data[DATA_W-1:0];
            end else if (!mode.wide && mode.intg) begin
                we      = HALF_BOTH;
                wr_data = {{DATA_W{ld_data[DATA_W-1]}}, ld_data};
            end else begin
                we = pick_hi ? HALF_HI : HALF_LO;
            end
        end
    end

endmodule

// File: rtl/cop_host_move.sv
module cop_host_move
    import cop_xfer_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int REG_W = 2 * DATA_W
) (
    input  logic              mv_wr,
    input  logic              mv_rd,
    input  logic              mv_upper,
    input  logic              blocked,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [REG_W-1:0]  rd_data,
    output logic              rd_ok,
    output half_e             we,
    output logic [REG_W-1:0]  wr_data,
    output logic [DATA_W-1:0] host_rdata
);

    always_comb begin
        rd_ok      = mv_rd && !blocked;
        we         = HALF_NONE;
        wr_data    = {host_wdata, host_wdata};
        host_rdata = '0;
        if (mv_wr && !blocked) begin
            we = mv_upper ? HALF_HI : HALF_LO;
        end
        if (rd_ok) begin
            host_rdata = mv_upper ? rd_data[REG_W-1:DATA_W] : rd_data[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/cop_xfer_seq.sv
module cop_xfer_seq
    import cop_xfer_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int INSTR_W  = 32,
    parameter int IDX_W    = 4,
    parameter int WIDE_BIT = 22,
    parameter int DST_LSB  = 12,
    parameter int MOV_LSB  = 16,
    parameter int BEATS    = 2,
    localparam int REG_W   = 2 * DATA_W,
    localparam int CNT_W   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phase_start,
    input  logic               beat_vld,
    input  logic               is_store,
    input  logic               is_int,
    input  logic               big_endian,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  ld_data,
    output logic [DATA_W-1:0]  st_data,
    output logic               beat_more,
    output logic               beat_done,
    input  logic               mv_wr,
    input  logic               mv_rd,
    input  logic               mv_upper,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic [1:0]         rf_we,
    output logic [IDX_W-1:0]   rf_wr_idx,
    output logic [REG_W-1:0]   rf_wr_data,
    output logic [IDX_W-1:0]   rf_rd_idx,
    input  logic [REG_W-1:0]   rf_rd_data
);

    logic             beat_acc;
    logic [CNT_W-1:0] beat_cnt;
    logic [IDX_W-1:0] xfer_idx;
    xfer_mode_t       mode;
    half_e            xfer_we, mv_we;
    logic [REG_W-1:0] xfer_wdata, mv_wdata;
    logic             mv_rd_ok;
    logic [IDX_W-1:0] mv_idx;

    assign mv_idx = instr[MOV_LSB +: IDX_W];

    cop_xfer_ctrl #(
        .INSTR_W (INSTR_W),
        .IDX_W   (IDX_W),
        .WIDE_BIT(WIDE_BIT),
        .DST_LSB (DST_LSB),
        .BEATS   (BEATS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_start(phase_start),
        .beat_vld   (beat_vld),
        .is_store   (is_store),
        .is_int     (is_int),
        .instr      (instr),
        .beat_acc   (beat_acc),
        .beat_cnt   (beat_cnt),
        .reg_idx    (xfer_idx),
        .mode       (mode),
        .more       (beat_more),
        .done       (beat_done)
    );

    cop_xfer_steer #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_steer (
        .beat_acc  (beat_acc),
        .beat_cnt  (beat_cnt),
        .mode      (mode),
        .big_endian(big_endian),
        .ld_data   (ld_data),
        .rd_data   (rf_rd_data),
        .we        (xfer_we),
        .wr_data   (xfer_wdata),
        .st_data   (st_data)
    );

    cop_host_move #(
        .DATA_W(DATA_W)
    ) u_move (
        .mv_wr     (mv_wr),
        .mv_rd     (mv_rd),
        .mv_upper  (mv_upper),
        .blocked   (phase_start || beat_vld),
        .host_wdata(host_wdata),
        .rd_data   (rf_rd_data),
        .rd_ok     (mv_rd_ok),
        .we        (mv_we),
        .wr_data   (mv_wdata),
        .host_rdata(host_rdata)
    );

    // transfer beats own the ports; host moves only run in idle cycles
    always_comb begin
        if (beat_acc) begin
            rf_we      = xfer_we;
            rf_wr_idx  = xfer_idx;
            rf_wr_data = xfer_wdata;
        end else begin
            rf_we      = mv_we;
            rf_wr_idx  = mv_idx;
            rf_wr_data = mv_wdata;
        end
        rf_rd_idx = mv_rd_ok ? mv_idx : xfer_idx;
    end

endmodule

// File: rtl/cop_xfer_chk.sv
module cop_xfer_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    localparam int REG_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phase_start,
    input logic              beat_vld,
    input logic              is_store,
    input logic              beat_more,
    input logic              beat_done,
    input logic [1:0]        rf_we,
    input logic [REG_W-1:0]  rf_wr_data,
    input logic [DATA_W-1:0] host_rdata
);

    logic pend_q;
    logic store_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            store_q <= 1'b0;
        end else begin
            if (phase_start) begin
                pend_q  <= 1'b0;
                store_q <= is_store;
            end else if (beat_more) begin
                pend_q <= 1'b1;
            end else if (beat_done) begin
                pend_q <= 1'b0;
            end
        end
    end

    a_r2_start_done: assert property (@(posedge clk) disable iff (!rst_n)
        phase_start |-> (beat_done && !beat_more));

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_more && beat_done));

    a_r12_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_more || beat_done) |-> (phase_start || beat_vld));

    a_r3_one_more: assert property (@(posedge clk) disable iff (!rst_n)
        beat_more |-> !pend_q);

    a_r7_store_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && !phase_start && store_q) |-> (rf_we == 2'b00));

    a_r6_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we == 2'b11) |->
            (beat_done && rf_wr_data[REG_W-1:DATA_W] == {DATA_W{rf_wr_data[DATA_W-1]}}));

    a_r11_move_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_start || beat_vld) |-> (host_rdata == '0));

endmodule

bind cop_xfer_seq cop_xfer_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/cop_xfer_seq_bench.sv
module cop_xfer_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_start = 1'b0, beat_vld = 1'b0, is_store = 1'b0, is_int = 1'b0;
    logic        big_endian = 1'b0;
    logic [31:0] instr = '0, ld_data = '0, host_wdata = '0;
    logic        mv_wr = 1'b0, mv_rd = 1'b0, mv_upper = 1'b0;
    logic [31:0] st_data, host_rdata;
    logic        beat_more, beat_done;
    logic [1:0]  rf_we;
    logic [3:0]  rf_wr_idx, rf_rd_idx;
    logic [63:0] rf_wr_data, rf_rd_data;
    logic [63:0] regs [16];

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    assign rf_rd_data = regs[rf_rd_idx];

    always @(posedge clk) begin
        if (rf_we[0]) regs[rf_wr_idx][31:0]  <= rf_wr_data[31:0];
        if (rf_we[1]) regs[rf_wr_idx][63:32] <= rf_wr_data[63:32];
    end

    cop_xfer_seq u_cop_xfer_seq (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic wide, logic [3:0] dst, logic [3:0] mvi);
        logic [31:0] w = '0;
        w[22]    = wide;
        w[15:12] = dst;
        w[19:16] = mvi;
        return w;
    endfunction

    task automatic idle();
        phase_start = 0; beat_vld = 0; mv_wr = 0; mv_rd = 0;
    endtask

    task automatic start(logic wide, logic [3:0] dst, logic st, logic it);
        @(negedge clk);
        idle();
        instr = mk(wide, dst, 4'd0); is_store = st; is_int = it; phase_start = 1;
        #1;
        chk("R2 start done", {beat_more, beat_done}, 64'b01);
    endtask

    task automatic beat(logic [31:0] d, logic be);
        @(negedge clk);
        idle();
        beat_vld = 1; ld_data = d; big_endian = be;
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk); idle(); #1;
        chk("R1 reset quiet", {rf_we, beat_more, beat_done}, 64'd0);
    endtask

    task automatic t_wide_load(logic be, logic [3:0] dst);
        start(1, dst, 0, 0);
        beat(32'hA1A1_0001, be);
        chk("R3 beat0 more", {beat_more, beat_done}, 64'b10);
        chk("R4 beat0 half", rf_we, be ? 2'b10 : 2'b01);
        chk("R4 beat0 idx", rf_wr_idx, dst);
        chk("R4 beat0 data", rf_wr_data, 64'hA1A1_0001_A1A1_0001);
        beat(32'hB2B2_0002, be);
        chk("R3 beat1 done", {beat_more, beat_done}, 64'b01);
        chk("R4 beat1 half", rf_we, be ? 2'b01 : 2'b10);
        @(negedge clk); idle(); mv_rd = 1; mv_upper = 1; instr = mk(0, 0, dst); #1;
        chk("R10 read upper", host_rdata, be ? 32'hA1A1_0001 : 32'hB2B2_0002);
        mv_upper = 0; #0.5;
        chk("R10 read lower", host_rdata, be ? 32'hB2B2_0002 : 32'hA1A1_0001);
        beat(32'h0, be);
        chk("R3 restart count", {beat_more, beat_done}, 64'b10);
        idle();
    endtask

    task automatic t_single_loads();
        start(0, 4'd6, 0, 0);
        beat(32'hC3C3_C3C3, 0);
        chk("R5 float load half", rf_we, 2'b10);
        chk("R5 float load done", {beat_more, beat_done}, 64'b01);
        start(0, 4'd7, 0, 1);
        beat(32'h8000_0001, 1);
        chk("R6 int load both", rf_we, 2'b11);
        chk("R6 sign neg", rf_wr_data, 64'hFFFF_FFFF_8000_0001);
        beat(32'h0000_0007, 0);
        chk("R6 sign pos", rf_wr_data, 64'h0000_0000_0000_0007);
        idle();
    endtask

    task automatic t_stores();
        @(negedge clk); idle();
        regs[9] = 64'h1111_2222_3333_4444;
        for (int be = 0; be < 2; be++) begin
            start(1, 4'd9, 1, 0);
            beat(32'h0, be[0]);
            chk("R7 wide store beat0", st_data, be ? 32'h1111_2222 : 32'h3333_4444);
            chk("R7 store no write", rf_we, 2'b00);
            chk("R3 store more", {beat_more, beat_done}, 64'b10);
            beat(32'h0, be[0]);
            chk("R7 wide store beat1", st_data, be ? 32'h3333_4444 : 32'h1111_2222);
        end
        start(0, 4'd9, 1, 0);
        beat(32'h0, 0);
        chk("R8 float store upper", st_data, 32'h1111_2222);
        start(0, 4'd9, 1, 1);
        beat(32'h0, 1);
        chk("R8 int store lower", st_data, 32'h3333_4444);
        chk("R8 int store done", {beat_more, beat_done}, 64'b01);
        idle();
    endtask

    task automatic t_abort();
        start(1, 4'd1, 0, 0);
        beat(32'h5555_5555, 0);
        chk("R3 abort pre more", beat_more, 1'b1);
        @(negedge clk); idle();
        instr = mk(0, 4'd2, 4'd0); is_store = 0; is_int = 0;
        phase_start = 1; beat_vld = 1; ld_data = 32'h6666_6666; #1;
        chk("R2 abort done", {beat_more, beat_done}, 64'b01);
        chk("R2 beat ignored", rf_we, 2'b00);
        beat(32'h7777_7777, 0);
        chk("R2 new mode half", rf_we, 2'b10);
        chk("R2 new mode idx", rf_wr_idx, 4'd2);
        chk("R2 count cleared", {beat_more, beat_done}, 64'b01);
        idle();
    endtask

    task automatic t_moves();
        @(negedge clk); idle();
        instr = mk(0, 0, 4'd4); mv_wr = 1; mv_upper = 0; host_wdata = 32'hDEAD_0004; #1;
        chk("R9 write lower", rf_we, 2'b01);
        chk("R9 write idx", rf_wr_idx, 4'd4);
        chk("R9 write data", rf_wr_data[31:0], 32'hDEAD_0004);
        @(negedge clk); mv_upper = 1; host_wdata = 32'hBEEF_0004; #1;
        chk("R9 write upper", rf_we, 2'b10);
        @(negedge clk); idle(); mv_rd = 1; mv_upper = 1; #1;
        chk("R10 idx", rf_rd_idx, 4'd4);
        chk("R10 read back", host_rdata, 32'hBEEF_0004);
        mv_rd = 0; #0.5;
        chk("R10 idle zero", host_rdata, 32'h0);
        // collisions
        start(0, 4'd6, 0, 0);
        @(negedge clk); idle();
        beat_vld = 1; ld_data = 32'h1234_5678; big_endian = 0;
        instr = mk(0, 0, 4'd4); mv_wr = 1; mv_upper = 0; host_wdata = 32'hFFFF_0000; mv_rd = 1; #1;
        chk("R11 beat wins we", rf_we, 2'b10);
        chk("R11 beat wins idx", rf_wr_idx, 4'd6);
        chk("R11 beat wins data", rf_wr_data[63:32], 32'h1234_5678);
        chk("R11 read blocked", host_rdata, 32'h0);
        @(negedge clk); idle(); phase_start = 1; mv_rd = 1; mv_upper = 1; instr = mk(0, 4'd3, 4'd4); #1;
        chk("R11 start blocks read", host_rdata, 32'h0);
        chk("R12 start no more", beat_more, 1'b0);
        idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_wide_load(0, 4'd3);
        t_wide_load(1, 4'd5);
        t_single_loads();
        t_stores();
        t_abort();
        t_moves();
        @(negedge clk); idle(); #1;
        chk("R12 quiet end", {beat_more, beat_done}, 64'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule